// File: doc/BRIEF.md
# Serial Port Line Status Tracker

This block keeps the line-status byte of a serial port that buffers received and transmitted characters in two 16-entry FIFOs. Each character that the receive shifter completes arrives with its data, its received parity bit, a framing-error flag and a break flag. The block works out the parity error from the programmed parity mode and stores all three error flags in the FIFO entry next to the data. The status byte always shows the flags of the entry at the head of the receive FIFO, together with a summary bit that stays set while any held entry carries an error.

On the transmit side the block holds the transmit FIFO and hands bytes to a shifter through a valid/take handshake. The shifter signals with a done pulse when it has finished sending. The status byte reports when the FIFO is empty and when both the FIFO and the shift register are empty. The receive overrun bit is cleared by a read of the status byte. Popping the receive FIFO is the only way to retire the per-character flags. Serial framing and baud timing are outside this block.

Top module: `lsr_tracker`

## Requirements
- R1: Status bit 0 is 1 exactly while the receive FIFO holds at least one entry. `rhrData` shows the head entry's data, and entries leave in arrival order, one per `rhrRead` pulse.
- R2: Status bits 2 (parity error), 3 (framing error) and 4 (break) show the flags stored with the head entry. They are 0 while the receive FIFO is empty.
- R3: `parSel[0]`=0 disables parity, so no parity error is ever flagged. With `parSel[0]`=1, `parSel[2:1]` selects the expected parity bit: 00 makes the total count of ones odd, 01 makes it even, 10 expects 1 and 11 expects 0. A parity error is stored when `rxParBit` differs from the expected bit.
- R4: A completion with `rxBreak`=1 stores data 0x00 with the break flag set and the parity and framing flags clear. Further break completions that follow it directly store nothing. The next completion without break re-arms break storage.
- R5: A completion that arrives while the receive FIFO holds 16 entries sets status bit 1 and is dropped. The 16 held entries stay unchanged and in order.
- R6: A `lsrRead` pulse clears status bit 1. A new overrun in the same cycle leaves it set.
- R7: Status bit 7 is 1 while any entry in the receive FIFO has a parity, framing or break flag. It is recomputed after every pop.
- R8: Status bit 5 is 1 while the transmit FIFO is empty. It goes to 0 in the cycle after a `thrWrite`.
- R9: Status bit 6 is 1 only when the transmit FIFO is empty and the shift register is idle. The shift register becomes busy on an accepted `txTake` (taken while `txValid`=1) and idle on `txDone`. `txValid` is 1 when the FIFO is non-empty and the shift register is idle.
- R10: After reset the status byte is 0x60 and `txValid` is 0.
- R11: The transmit FIFO delivers bytes in write order on `txByte`. A `thrWrite` while it holds 16 bytes is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| parSel | input | 3 | Parity mode: bit 0 enable, bits 2:1 kind |
| rxDone | input | 1 | Receive shifter completed a character (pulse) |
| rxData | input | 8 | Completed character data |
| rxParBit | input | 1 | Parity bit received with the character |
| rxFrmErr | input | 1 | Stop bit was invalid |
| rxBreak | input | 1 | Line was low for a whole frame |
| rhrRead | input | 1 | Read (pop) of the receive head |
| rhrData | output | 8 | Data of the receive head entry |
| thrWrite | input | 1 | Write into the transmit FIFO |
| thrData | input | 8 | Byte to transmit |
| txValid | output | 1 | A byte is offered to the transmit shifter |
| txByte | output | 8 | Offered byte |
| txTake | input | 1 | Transmit shifter takes the offered byte |
| txDone | input | 1 | Transmit shifter finished its byte |
| lsrRead | input | 1 | Read of the status byte |
| lsrByte | output | 8 | Line status byte |

## Verification
The receive path is driven with clean characters, with characters whose parity bit matches or misses under each of the four parity kinds and with parity disabled, and with framing errors. These runs show whether the head flags follow the right entry. Flagged entries are placed both in front of and behind clean ones, which separates a summary bit computed over the whole FIFO from one that copies the head. A run of repeated breaks followed by a clean byte and another break shows that one entry is stored per break and that break storage re-arms. Filling the FIFO and then overflowing it, with and without a same-cycle status read, shows the drop rule, the clear-on-read and its priority. On the transmit side, single bytes go through the take and done handshake and a 17-byte burst is sent, which separates the two empty indications and checks order and the full-write drop.

// File: rtl/lsr_pkg.sv
`timescale 1ns/1ps
package lsr_pkg;

  typedef struct packed {
    logic       brk;
    logic       frm;
    logic       par;
    logic [7:0] data;
  } rxEntry_t;

  typedef struct packed {
    logic rxPush;
    logic rxPop;
    logic txPush;
    logic txPop;
  } fifoStrobe_t;

  // Expected parity bit for kind: 00 odd, 01 even, 10 one, 11 zero.
  function automatic logic expectedParity(input logic [1:0] kind, input logic [7:0] d);
    logic bitOut;
    case (kind)
      2'b00:   bitOut = ~(^d);
      2'b01:   bitOut = ^d;
      2'b10:   bitOut = 1'b1;
      default: bitOut = 1'b0;
    endcase
    return bitOut;
  endfunction

endpackage

// File: rtl/lsr_fifo.sv
`timescale 1ns/1ps
module lsr_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic [CNT_W-1:0] count
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= din;
  end

  assign dout = mem[rdPtr];
endmodule

// File: rtl/lsr_datapath.sv
`timescale 1ns/1ps
module lsr_datapath
  import lsr_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoStrobe_t      strobe,
  input  rxEntry_t         rxNewEntry,
  input  logic [7:0]       thrData,
  output rxEntry_t         rxHead,
  output logic [7:0]       txHead,
  output logic [CNT_W-1:0] rxCount,
  output logic [CNT_W-1:0] txCount
);
  localparam int ENTRY_W = $bits(rxEntry_t);

  logic [ENTRY_W-1:0] rxHeadBits;

  lsr_fifo #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) rxFifo_i (
    .clk(clk), .rstN(rstN),
    .push(strobe.rxPush), .pop(strobe.rxPop),
    .din(rxNewEntry), .dout(rxHeadBits), .count(rxCount)
  );

  lsr_fifo #(.WIDTH(8), .DEPTH(DEPTH)) txFifo_i (
    .clk(clk), .rstN(rstN),
    .push(strobe.txPush), .pop(strobe.txPop),
    .din(thrData), .dout(txHead), .count(txCount)
  );

  assign rxHead = rxEntry_t'(rxHeadBits);
endmodule

// File: rtl/lsr_ctrl.sv
`timescale 1ns/1ps
module lsr_ctrl
  import lsr_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       parSel,
  input  logic             rxDone,
  input  logic [7:0]       rxData,
  input  logic             rxParBit,
  input  logic             rxFrmErr,
  input  logic             rxBreak,
  input  logic             rhrRead,
  input  logic             thrWrite,
  input  logic             txTake,
  input  logic             txDone,
  input  logic             lsrRead,
  input  rxEntry_t         rxHead,
  input  logic [CNT_W-1:0] rxCount,
  input  logic [CNT_W-1:0] txCount,
  output fifoStrobe_t      strobe,
  output rxEntry_t         rxNewEntry,
  output logic             txValid,
  output logic [7:0]       lsrByte
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic             brkSeen, overrun, tsrBusy;
  logic [CNT_W-1:0] errCount;
  logic             rxFull, rxAccept, headValid, txEmpty, newErr, headErr;

  assign rxFull    = (rxCount == FULL);
  assign headValid = (rxCount != '0);
  assign txEmpty   = (txCount == '0);
  assign rxAccept  = rxDone && !(rxBreak && brkSeen);

  always_comb begin
    rxNewEntry.data = rxBreak ? 8'h00 : rxData;
    rxNewEntry.brk  = rxBreak;
    rxNewEntry.frm  = !rxBreak && rxFrmErr;
    rxNewEntry.par  = !rxBreak && parSel[0] &&
                      (rxParBit != expectedParity(parSel[2:1], rxData));
  end

  assign txValid = !txEmpty && !tsrBusy;

  always_comb begin
    strobe.rxPush = rxAccept && !rxFull;
    strobe.rxPop  = rhrRead && headValid;
    strobe.txPush = thrWrite && (txCount != FULL);
    strobe.txPop  = txTake && txValid;
  end

  assign newErr  = rxNewEntry.brk || rxNewEntry.frm || rxNewEntry.par;
  assign headErr = rxHead.brk || rxHead.frm || rxHead.par;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      brkSeen  <= 1'b0;
      overrun  <= 1'b0;
      tsrBusy  <= 1'b0;
      errCount <= '0;
    end else begin
      if (rxDone) brkSeen <= rxBreak;
      if (rxAccept && rxFull) overrun <= 1'b1;
      else if (lsrRead)       overrun <= 1'b0;
      if (strobe.txPop)       tsrBusy <= 1'b1;
      else if (txDone)        tsrBusy <= 1'b0;
      case ({strobe.rxPush && newErr, strobe.rxPop && headErr})
        2'b10:   errCount <= errCount + 1'b1;
        2'b01:   errCount <= errCount - 1'b1;
        default: errCount <= errCount;
      endcase
    end
  end

  assign lsrByte = {
    (errCount != '0),
    txEmpty && !tsrBusy,
    txEmpty,
    headValid && rxHead.brk,
    headValid && rxHead.frm,
    headValid && rxHead.par,
    overrun,
    headValid
  };
endmodule

// File: rtl/lsr_tracker.sv
`timescale 1ns/1ps
module lsr_tracker
  import lsr_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] parSel,
  input  logic       rxDone,
  input  logic [7:0] rxData,
  input  logic       rxParBit,
  input  logic       rxFrmErr,
  input  logic       rxBreak,
  input  logic       rhrRead,
  output logic [7:0] rhrData,
  input  logic       thrWrite,
  input  logic [7:0] thrData,
  output logic       txValid,
  output logic [7:0] txByte,
  input  logic       txTake,
  input  logic       txDone,
  input  logic       lsrRead,
  output logic [7:0] lsrByte
);
  fifoStrobe_t      strobe;
  rxEntry_t         rxNewEntry, rxHead;
  logic [CNT_W-1:0] rxCount, txCount;

  lsr_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .parSel(parSel),
    .rxDone(rxDone), .rxData(rxData), .rxParBit(rxParBit),
    .rxFrmErr(rxFrmErr), .rxBreak(rxBreak), .rhrRead(rhrRead),
    .thrWrite(thrWrite), .txTake(txTake), .txDone(txDone),
    .lsrRead(lsrRead), .rxHead(rxHead), .rxCount(rxCount),
    .txCount(txCount), .strobe(strobe), .rxNewEntry(rxNewEntry),
    .txValid(txValid), .lsrByte(lsrByte)
  );

  lsr_datapath #(.DEPTH(DEPTH)) data_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rxNewEntry(rxNewEntry),
    .thrData(thrData), .rxHead(rxHead), .txHead(txByte),
    .rxCount(rxCount), .txCount(txCount)
  );

  assign rhrData = rxHead.data;
endmodule

// File: rtl/lsr_tracker_chk.sv
`timescale 1ns/1ps
module lsr_tracker_chk #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             rxDone,
  input logic             rxBreak,
  input logic             rhrRead,
  input logic             thrWrite,
  input logic             lsrRead,
  input logic             txValid,
  input logic [7:0]       lsrByte,
  input logic [CNT_W-1:0] rxCount
);
  assert_ready_after_done_R1: assert property (@(posedge clk) disable iff (!rstN)
    (rxDone && !rhrRead) |=> lsrByte[0]);

  assert_overrun_on_full_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rxDone && !rxBreak && rxCount == CNT_W'(DEPTH)) |=> lsrByte[1]);

  assert_overrun_cleared_R6: assert property (@(posedge clk) disable iff (!rstN)
    (lsrRead && !rxDone) |=> !lsrByte[1]);

  assert_summary_covers_head_R7: assert property (@(posedge clk) disable iff (!rstN)
    (|lsrByte[4:2]) |-> lsrByte[7]);

  assert_write_clears_empty_R8: assert property (@(posedge clk) disable iff (!rstN)
    thrWrite |=> !lsrByte[5]);

  assert_all_empty_needs_fifo_empty_R9: assert property (@(posedge clk) disable iff (!rstN)
    lsrByte[6] |-> lsrByte[5]);

  assert_offer_means_nonempty_R9: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> !lsrByte[5]);
endmodule

bind lsr_tracker lsr_tracker_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rstN(rstN), .rxDone(rxDone), .rxBreak(rxBreak),
  .rhrRead(rhrRead), .thrWrite(thrWrite), .lsrRead(lsrRead),
  .txValid(txValid), .lsrByte(lsrByte), .rxCount(rxCount)
);

// File: tb/lsr_tracker_tb_top.sv
`timescale 1ns/1ps
module lsr_tracker_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] parSel = '0;
  logic       rxDone = 0, rxParBit = 0, rxFrmErr = 0, rxBreak = 0, rhrRead = 0;
  logic [7:0] rxData = '0, thrData = '0;
  logic       thrWrite = 0, txTake = 0, txDone = 0, lsrRead = 0;
  logic [7:0] rhrData, txByte, lsrByte;
  logic       txValid;
  int         nChecks = 0, nFails = 0;

  always #2.5 clk = ~clk;

  lsr_tracker dut_i (
    .clk(clk), .rstN(rstN), .parSel(parSel), .rxDone(rxDone), .rxData(rxData),
    .rxParBit(rxParBit), .rxFrmErr(rxFrmErr), .rxBreak(rxBreak),
    .rhrRead(rhrRead), .rhrData(rhrData), .thrWrite(thrWrite),
    .thrData(thrData), .txValid(txValid), .txByte(txByte), .txTake(txTake),
    .txDone(txDone), .lsrRead(lsrRead), .lsrByte(lsrByte)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic rxChar(input logic [7:0] d, input logic pb, input logic frm, input logic brk);
    rxDone = 1; rxData = d; rxParBit = pb; rxFrmErr = frm; rxBreak = brk;
    step();
    rxDone = 0; rxFrmErr = 0; rxBreak = 0; rxParBit = 0;
  endtask

  task automatic readRhr();
    rhrRead = 1; step(); rhrRead = 0;
  endtask

  task automatic readLsr();
    lsrRead = 1; step(); lsrRead = 0;
  endtask

  task automatic writeThr(input logic [7:0] d);
    thrWrite = 1; thrData = d; step(); thrWrite = 0;
  endtask

  task automatic testReset();
    chk("R10 reset status", lsrByte, 8'h60);
    chk("R10 reset txValid", txValid, 1'b0);
  endtask

  task automatic testRxBasic();
    parSel = 3'b000;
    rxChar(8'hA5, 1'b1, 1'b0, 1'b0);
    rxChar(8'h3C, 1'b0, 1'b0, 1'b0);
    chk("R1 data ready", lsrByte, 8'h61);
    chk("R1 head data first", rhrData, 8'hA5);
    readRhr();
    chk("R1 head data second", rhrData, 8'h3C);
    readRhr();
    chk("R1 empty after drain", lsrByte, 8'h60);
  endtask

  task automatic testParity();
    for (int m = 0; m < 4; m++) begin
      logic expBit;
      expBit = (m == 0) ? ~(^8'h07) : (m == 1) ? ^8'h07 : (m == 2) ? 1'b1 : 1'b0;
      parSel = {2'(m), 1'b1};
      rxChar(8'h07, expBit, 1'b0, 1'b0);
      chk("R3 matching parity no error", lsrByte, 8'h61);
      readRhr();
      rxChar(8'h07, ~expBit, 1'b0, 1'b0);
      chk("R3 parity error flagged R2", lsrByte, 8'hE5);
      readRhr();
      chk("R7 cleared after pop", lsrByte, 8'h60);
    end
    parSel = 3'b110;
    rxChar(8'h07, 1'b1, 1'b0, 1'b0);
    chk("R3 disabled parity ignored", lsrByte, 8'h61);
    readRhr();
    rxChar(8'h5A, 1'b0, 1'b1, 1'b0);
    chk("R2 framing flag at head", lsrByte, 8'hE9);
    readRhr();
    chk("R2 flags zero when empty", lsrByte, 8'h60);
  endtask

  task automatic testBreak();
    parSel = 3'b000;
    rxChar(8'hFF, 1'b0, 1'b0, 1'b1);
    rxChar(8'hFF, 1'b0, 1'b0, 1'b1);
    rxChar(8'hFF, 1'b0, 1'b0, 1'b1);
    rxChar(8'h11, 1'b0, 1'b0, 1'b0);
    rxChar(8'hFF, 1'b0, 1'b0, 1'b1);
    chk("R4 break head status", lsrByte, 8'hF1);
    chk("R4 break data zero", rhrData, 8'h00);
    readRhr();
    chk("R4 single break entry", rhrData, 8'h11);
    chk("R7 break still held behind head", lsrByte, 8'hE1);
    readRhr();
    chk("R4 rearmed break entry", lsrByte, 8'hF1);
    readRhr();
    chk("R4 three entries only", lsrByte, 8'h60);
  endtask

  task automatic testSummary();
    parSel = 3'b000;
    rxChar(8'h21, 1'b0, 1'b1, 1'b0);
    rxChar(8'h22, 1'b0, 1'b0, 1'b0);
    chk("R7 error at head", lsrByte, 8'hE9);
    readRhr();
    chk("R7 recomputed after pop", lsrByte, 8'h61);
    rxChar(8'h23, 1'b0, 1'b1, 1'b0);
    chk("R7 error behind clean head", lsrByte, 8'hE1);
    readRhr();
    chk("R7 error now at head", lsrByte, 8'hE9);
    readRhr();
    chk("R7 empty clean", lsrByte, 8'h60);
  endtask

  task automatic testOverrun();
    parSel = 3'b000;
    for (int i = 0; i < 16; i++) rxChar(8'(i + 8'h40), 1'b0, 1'b0, 1'b0);
    chk("R5 full no overrun yet", lsrByte[1], 1'b0);
    lsrRead = 1;
    rxChar(8'hEE, 1'b0, 1'b0, 1'b0);
    lsrRead = 0;
    chk("R6 set wins over read", lsrByte[1], 1'b1);
    rxChar(8'hEF, 1'b0, 1'b0, 1'b0);
    chk("R5 overrun set", lsrByte, 8'h63);
    readLsr();
    chk("R6 cleared by status read", lsrByte[1], 1'b0);
    for (int i = 0; i < 16; i++) begin
      chk("R5 FIFO intact", rhrData, 8'(i + 8'h40));
      readRhr();
    end
    chk("R5 dropped bytes absent", lsrByte, 8'h60);
  endtask

  task automatic testTx();
    writeThr(8'h41);
    chk("R8 write clears empty", lsrByte, 8'h00);
    chk("R9 offered", txValid, 1'b1);
    chk("R11 offered byte", txByte, 8'h41);
    txTake = 1; step(); txTake = 0;
    chk("R9 shifter busy fifo empty", lsrByte, 8'h20);
    chk("R9 no offer while busy", txValid, 1'b0);
    txDone = 1; step(); txDone = 0;
    chk("R9 all empty", lsrByte, 8'h60);
    for (int i = 0; i < 17; i++) writeThr(8'(i + 8'h80));
    for (int i = 0; i < 16; i++) begin
      chk("R11 order", txByte, 8'(i + 8'h80));
      txTake = 1; step(); txTake = 0;
      txDone = 1; step(); txDone = 0;
    end
    chk("R11 extra write dropped", txValid, 1'b0);
    chk("R8 empty after drain", lsrByte, 8'h60);
  endtask

  initial begin
    repeat (3) step();
    rstN = 1;
    step();
    testReset();
    testRxBasic();
    testParity();
    testBreak();
    testSummary();
    testOverrun();
    testTx();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule